// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central hazard controller of an in-order-issue, out-of-order-completion pipeline. It watches a stream of decoded instructions, each with an operation code, one destination register and two source registers. It moves each instruction through four steps: issue, operand read, execution complete and result write. There are five functional units: one integer/load unit, two multipliers, one adder/subtractor and one divider. Each unit runs a fixed-latency countdown. Only the bookkeeping is modelled. No data values, arithmetic or register file are present.

For each unit the controller keeps a record with these fields:
- a busy flag and the operation;
- the destination register and the two source registers;
- for each source, the unit that will produce it and a flag that says the source is ready to read.

A register result status table names, for each register, the unit that will write it next. Results are never forwarded. A consumer waits until its producer has written the register, then reads it in a later cycle.

Instructions enter on a valid/ready handshake. An instruction is taken in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is computed from the payload being offered, so the payload must be stable while `in_valid` is high. The sender may withdraw an instruction that was not taken. Each step transition of each unit is reported as a one-cycle pulse. `unit_idx` shows the instruction index held by each unit.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy, every result status entry reads 0, no step pulse is high, and an instruction of a known op with any destination is accepted. Op codes: 0 load, 1 multiply, 2 add, 3 subtract, 4 divide; codes 5 to 7 are never accepted.
- R2: Unit codes are 0 integer/load, 1 first multiplier, 2 second multiplier, 3 adder, 4 divider. A multiply takes the first multiplier when it is free and otherwise the second. `in_ready` is low while no unit for the offered op is free.
- R3: `in_ready` is low while the offered destination register already has a pending writer (its status entry is nonzero). It rises in the cycle after that writer's write pulse.
- R4: A taken instruction pulses `ev_issue` in its handshake cycle, with `ev_issue_unit` giving the chosen unit. From the next cycle the destination's status entry holds unit code + 1.
- R5: A unit reads operands only when no source it uses has a pending writer. The earliest read is one cycle after issue, or one cycle after the last producer's write pulse.
- R6: The completion pulse of a unit comes exactly L cycles after its read pulse. L is 1 for load, 2 for add/subtract, the multiply latency for multiply and the divide latency for divide (defaults 10 and 40).
- R7: A completed unit does not write while a unit issued earlier still has an unread source equal to its destination. It writes one cycle after that reader's read pulse at the earliest.
- R8: The write pulse comes at least one cycle after the completion pulse. In the next cycle the unit is free and the destination's status entry reads 0.
- R9: A load uses only its first source. A pending writer of its second source neither delays its read nor is delayed by it.
- R10: Completion and write may occur out of issue order. A short operation issued after a long one writes first.
- R11: An instruction issued in the same cycle as its source's producer writes is treated as having that source ready. It reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction can be taken this cycle |
| in_op | input | 3 | Operation code (R1) |
| in_dst | input | log2(NREG) | Destination register |
| in_src1 | input | log2(NREG) | First source register |
| in_src2 | input | log2(NREG) | Second source register (unused by load) |
| in_idx | input | IDXW | Instruction index carried for reporting |
| ev_issue | output | 1 | Issue pulse |
| ev_issue_unit | output | 3 | Unit chosen at issue |
| ev_read | output | 5 | Per-unit operand read pulse |
| ev_done | output | 5 | Per-unit execution complete pulse |
| ev_write | output | 5 | Per-unit result write pulse |
| unit_idx | output | 5*IDXW | Instruction index held by each unit |
| rrs_status | output | NREG*3 | Per-register pending writer, unit code + 1, 0 for none |

## Verification
Two cases can fall in the same cycle. In the first, a producer's write and the issue of a consumer of that register happen together. The bench offers the consumer exactly in the producer's write cycle and expects the consumer's read one cycle later; a stale producer link would leave it waiting forever. In the second, a reader's operand read and a blocked writer's WAR check happen together. The bench expects the write to slip to the cycle after the read and confirms this through the status table. All expected pulse cycles are derived from the issue cycles and the stated latencies.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NFU = 5;
  localparam int UW  = $clog2(NFU + 1);

  localparam int FU_INT  = 0;
  localparam int FU_MUL1 = 1;
  localparam int FU_MUL2 = 2;
  localparam int FU_ADD  = 3;
  localparam int FU_DIV  = 4;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_MUL  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_DIV  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EXEC,
    ST_WB
  } step_e;
endpackage

// File: rtl/sb_issue.sv
module sb_issue import sb_pkg::*; #(
  parameter int CW       = 6,
  parameter int LAT_LOAD = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40
) (
  input  logic [2:0]     op,
  input  logic [NFU-1:0] fu_busy,
  output logic [UW-1:0]  unit,
  output logic           unit_ok,
  output logic [CW-1:0]  lat,
  output logic           uses2
);
  logic known;

  always_comb begin
    unit  = UW'(FU_ADD);
    lat   = CW'(LAT_ADD);
    uses2 = 1'b1;
    known = 1'b1;
    case (op_e'(op))
      OP_LOAD: begin
        unit  = UW'(FU_INT);
        lat   = CW'(LAT_LOAD);
        uses2 = 1'b0;
      end
      OP_MUL: begin
        unit = fu_busy[FU_MUL1] ? UW'(FU_MUL2) : UW'(FU_MUL1);
        lat  = CW'(LAT_MUL);
      end
      OP_ADD, OP_SUB: ;
      OP_DIV: begin
        unit = UW'(FU_DIV);
        lat  = CW'(LAT_DIV);
      end
      default: known = 1'b0;
    endcase
    unit_ok = known && !fu_busy[unit];
  end
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot import sb_pkg::*; #(
  parameter int RW   = 4,
  parameter int IDXW = 8,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_en,
  input  logic [RW-1:0]   iss_dst,
  input  logic [RW-1:0]   iss_s1,
  input  logic [RW-1:0]   iss_s2,
  input  logic [UW-1:0]   iss_q1,
  input  logic [UW-1:0]   iss_q2,
  input  logic            iss_use2,
  input  logic [CW-1:0]   iss_lat,
  input  logic [IDXW-1:0] iss_idx,
  input  logic [NFU-1:0]  wr_vec,
  input  logic            war_ok,
  output logic            busy,
  output logic [RW-1:0]   dst,
  output logic [RW-1:0]   src1,
  output logic [RW-1:0]   src2,
  output logic            pend1,
  output logic            pend2,
  output logic [IDXW-1:0] idx,
  output logic            read_fire,
  output logic            done_fire,
  output logic            write_fire
);
  step_e         st;
  logic [UW-1:0] q1_q, q2_q;
  logic          r1_q, r2_q, use2_q;
  logic [CW-1:0] lat_q, cnt_q;
  logic          q1_hit, q2_hit;

  assign q1_hit     = (q1_q != '0) && wr_vec[q1_q - 1'b1];
  assign q2_hit     = (q2_q != '0) && wr_vec[q2_q - 1'b1];
  assign read_fire  = (st == ST_WAIT) && r1_q && (r2_q || !use2_q);
  assign done_fire  = (st == ST_EXEC) && (cnt_q == CW'(1));
  assign write_fire = (st == ST_WB) && war_ok;
  assign busy       = (st != ST_IDLE);
  assign pend1      = (st == ST_WAIT) && r1_q;
  assign pend2      = (st == ST_WAIT) && r2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      dst    <= '0;
      src1   <= '0;
      src2   <= '0;
      q1_q   <= '0;
      q2_q   <= '0;
      r1_q   <= 1'b0;
      r2_q   <= 1'b0;
      use2_q <= 1'b0;
      lat_q  <= '0;
      cnt_q  <= '0;
      idx    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (issue_en) begin
          dst    <= iss_dst;
          src1   <= iss_s1;
          src2   <= iss_s2;
          q1_q   <= iss_q1;
          q2_q   <= iss_q2;
          r1_q   <= (iss_q1 == '0);
          r2_q   <= iss_use2 && (iss_q2 == '0);
          use2_q <= iss_use2;
          lat_q  <= iss_lat;
          idx    <= iss_idx;
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (q1_hit) begin r1_q <= 1'b1; q1_q <= '0; end
          if (q2_hit) begin r2_q <= 1'b1; q2_q <= '0; end
          if (read_fire) begin
            r1_q  <= 1'b0;
            r2_q  <= 1'b0;
            cnt_q <= lat_q;
            st    <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          cnt_q <= cnt_q - 1'b1;
          if (done_fire) st <= ST_WB;
        end
        ST_WB: if (write_fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_issue_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !busy) else $error("issue into busy unit");

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    read_fire |=> (!pend1 && !pend2)) else $error("read left source flags set");

  assert_done_to_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> (st == ST_WB)) else $error("completion did not enter write step");

  assert_write_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> !busy) else $error("unit still busy after write");
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl import sb_pkg::*; #(
  parameter int NREG     = 16,
  parameter int IDXW     = 8,
  parameter int LAT_LOAD = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40,
  localparam int RW      = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [RW-1:0]       in_dst,
  input  logic [RW-1:0]       in_src1,
  input  logic [RW-1:0]       in_src2,
  input  logic [IDXW-1:0]     in_idx,
  output logic                ev_issue,
  output logic [UW-1:0]       ev_issue_unit,
  output logic [NFU-1:0]      ev_read,
  output logic [NFU-1:0]      ev_done,
  output logic [NFU-1:0]      ev_write,
  output logic [NFU*IDXW-1:0] unit_idx,
  output logic [NREG*UW-1:0]  rrs_status
);
  localparam int LAT_A   = (LAT_LOAD > LAT_ADD) ? LAT_LOAD : LAT_ADD;
  localparam int LAT_B   = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int CW      = $clog2(LAT_MAX + 1);

  logic [UW-1:0]   rrs_q [NREG];
  logic [NFU-1:0]  fu_busy, rd_fire, dn_fire, wr_fire, war_ok, pr1, pr2;
  logic [RW-1:0]   sl_dst [NFU];
  logic [RW-1:0]   sl_s1  [NFU];
  logic [RW-1:0]   sl_s2  [NFU];
  logic [IDXW-1:0] sl_idx [NFU];
  logic [UW-1:0]   sel, w1, w2, q1, q2;
  logic            sel_ok, sel_use2, fire;
  logic [CW-1:0]   sel_lat;

  sb_issue #(.CW(CW), .LAT_LOAD(LAT_LOAD), .LAT_ADD(LAT_ADD),
             .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)) u_iss (
    .op(in_op), .fu_busy(fu_busy), .unit(sel), .unit_ok(sel_ok),
    .lat(sel_lat), .uses2(sel_use2)
  );

  assign in_ready = sel_ok && (rrs_q[in_dst] == '0);
  assign fire     = in_valid && in_ready;

  // Producer links taken at issue; a producer writing this very cycle counts as done.
  always_comb begin
    w1 = rrs_q[in_src1];
    w2 = rrs_q[in_src2];
    q1 = ((w1 != '0) && wr_fire[w1 - 1'b1]) ? '0 : w1;
    q2 = (!sel_use2 || ((w2 != '0) && wr_fire[w2 - 1'b1])) ? '0 : w2;
  end

  // WAR: hold a write while another unit still has to read the old value.
  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NFU; f++) begin
        if (f != u && ((pr1[f] && sl_s1[f] == sl_dst[u]) ||
                       (pr2[f] && sl_s2[f] == sl_dst[u])))
          war_ok[u] = 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    sb_fu_slot #(.RW(RW), .IDXW(IDXW), .CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .issue_en(fire && (sel == UW'(g))),
      .iss_dst(in_dst), .iss_s1(in_src1), .iss_s2(in_src2),
      .iss_q1(q1), .iss_q2(q2), .iss_use2(sel_use2),
      .iss_lat(sel_lat), .iss_idx(in_idx),
      .wr_vec(wr_fire), .war_ok(war_ok[g]),
      .busy(fu_busy[g]), .dst(sl_dst[g]), .src1(sl_s1[g]), .src2(sl_s2[g]),
      .pend1(pr1[g]), .pend2(pr2[g]), .idx(sl_idx[g]),
      .read_fire(rd_fire[g]), .done_fire(dn_fire[g]), .write_fire(wr_fire[g])
    );
    assign unit_idx[g*IDXW +: IDXW] = sl_idx[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rrs_q[r] <= '0;
    end else begin
      for (int u = 0; u < NFU; u++)
        if (wr_fire[u]) rrs_q[sl_dst[u]] <= '0;
      if (fire) rrs_q[in_dst] <= sel + 1'b1;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_rrs
    assign rrs_status[r*UW +: UW] = rrs_q[r];
  end

  assign ev_issue      = fire;
  assign ev_issue_unit = sel;
  assign ev_read       = rd_fire;
  assign ev_done       = dn_fire;
  assign ev_write      = wr_fire;

  assert_status_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rrs_q[$past(in_dst)] == ($past(sel) + UW'(1))))
    else $error("status entry not set after issue");
endmodule

// File: tb/sb_ctrl_tb.sv
module sb_ctrl_tb;
  localparam int NREG = 16;
  localparam int IDXW = 8;
  localparam int NU   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_op = 3'd2;
  logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [IDXW-1:0] in_idx = '0;
  logic ev_issue;
  logic [2:0] ev_issue_unit;
  logic [NU-1:0] ev_read, ev_done, ev_write;
  logic [NU*IDXW-1:0] unit_idx;
  logic [NREG*3-1:0] rrs_status;

  sb_ctrl #(.NREG(NREG), .IDXW(IDXW), .LAT_LOAD(1), .LAT_ADD(2),
            .LAT_MUL(4), .LAT_DIV(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_idx(in_idx), .ev_issue(ev_issue), .ev_issue_unit(ev_issue_unit),
    .ev_read(ev_read), .ev_done(ev_done), .ev_write(ev_write),
    .unit_idx(unit_idx), .rrs_status(rrs_status)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int key; string req; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit mon_en = 1'b0, finished = 1'b0;

  task automatic expect_ev(int c, int kind, int unit, string req);
    exp_t e;
    int pos = exp_q.size();
    e.key = c * 100 + kind * 10 + unit;
    e.req = req;
    for (int i = 0; i < exp_q.size(); i++)
      if (exp_q[i].key > e.key) begin pos = i; break; end
    exp_q.insert(pos, e);
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  task automatic mon_event(int key);
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event actual %0d expected none", key);
    end else if (exp_q[0].key == key) begin
      void'(exp_q.pop_front());
    end else begin
      n_bad++;
      $display("FAIL %s event actual %0d expected %0d", exp_q[0].req, key, exp_q[0].key);
      if (exp_q[0].key < key) void'(exp_q.pop_front());
    end
  endtask

  // Monitor: samples halfway between the falling edge and the next rising edge.
  initial begin
    forever begin
      @(posedge clk); #6;
      if (mon_en) begin
        while (exp_q.size() != 0 && exp_q[0].key / 100 < cyc) begin
          n_cmp++; n_bad++;
          $display("FAIL %s missed event actual none expected %0d", exp_q[0].req, exp_q[0].key);
          void'(exp_q.pop_front());
        end
        if (ev_issue) mon_event(cyc * 100 + int'(ev_issue_unit));
        for (int k = 1; k < 4; k++)
          for (int u = 0; u < NU; u++) begin
            logic [NU-1:0] v;
            v = (k == 1) ? ev_read : (k == 2) ? ev_done : ev_write;
            if (v[u]) mon_event(cyc * 100 + k * 10 + u);
          end
      end
    end
  end

  function automatic int rrs(int r);
    return int'(rrs_status[r*3 +: 3]);
  endfunction

  // Entered and left at 2 ns after a rising edge.
  task automatic do_issue(int op, int dst, int s1, int s2, int unit, string req, output int t);
    in_op = 3'(op); in_dst = 4'(dst); in_src1 = 4'(s1); in_src2 = 4'(s2);
    in_idx = in_idx + 1'b1; in_valid = 1'b1;
    #1;
    while (!in_ready) #8;
    t = cyc;
    expect_ev(t, 0, unit, req);
    #7;
    in_valid = 1'b0;
  endtask

  task automatic check_stall(int op, int dst, string req);
    in_op = 3'(op); in_dst = 4'(dst); in_src1 = 4'd1; in_src2 = 4'd1; in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, req, int'(in_ready), 0);
    #7;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic wait_cycle(int c);
    while (cyc < c) @(posedge clk);
    #2;
  endtask

  initial begin
    int t0, t1, t2, t3, t4, t5, t6, t7, t8, t9, t10;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: reset state
    check(rrs_status == '0, "R1 status", int'(rrs_status != '0), 0);
    check({ev_read, ev_done, ev_write} == '0, "R1 pulses", int'({ev_read, ev_done, ev_write}), 0);
    in_op = 3'd2;
    #1 check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    #7;
    check_stall(5, 0, "R1 unknown op");
    mon_en = 1'b1;

    // Load then dependent add: no forwarding
    do_issue(0, 1, 2, 0, 0, "R4", t0);
    expect_ev(t0 + 1, 1, 0, "R5"); expect_ev(t0 + 2, 2, 0, "R6"); expect_ev(t0 + 3, 3, 0, "R8");
    check(rrs(1) == 1, "R4 status load", rrs(1), 1);
    do_issue(2, 3, 1, 4, 3, "R4", t1);
    expect_ev(t0 + 4, 1, 3, "R5"); expect_ev(t0 + 6, 2, 3, "R6"); expect_ev(t0 + 7, 3, 3, "R8");
    check(t1 == t0 + 1, "R4 back to back", t1, t0 + 1);
    check(rrs(3) == 4, "R4 status add", rrs(3), 4);
    wait_idle();
    check(rrs_status == '0, "R8 status cleared", int'(rrs_status != '0), 0);

    // Structural and WAW stalls
    do_issue(1, 5, 1, 1, 1, "R2", t2);
    expect_ev(t2 + 1, 1, 1, "R5"); expect_ev(t2 + 5, 2, 1, "R6"); expect_ev(t2 + 6, 3, 1, "R8");
    do_issue(1, 6, 1, 1, 2, "R2", t3);
    expect_ev(t2 + 2, 1, 2, "R5"); expect_ev(t2 + 6, 2, 2, "R6"); expect_ev(t2 + 7, 3, 2, "R8");
    check_stall(1, 7, "R2 both multipliers busy");
    check_stall(4, 5, "R3 pending destination");
    do_issue(4, 5, 1, 1, 4, "R3", t4);
    check(t4 == t2 + 7, "R3 release cycle", t4, t2 + 7);
    expect_ev(t4 + 1, 1, 4, "R5"); expect_ev(t4 + 7, 2, 4, "R6"); expect_ev(t4 + 8, 3, 4, "R8");
    wait_idle();

    // WAR hold and out-of-order completion
    do_issue(1, 11, 1, 1, 1, "R4", t5);
    expect_ev(t5 + 1, 1, 1, "R5"); expect_ev(t5 + 5, 2, 1, "R6"); expect_ev(t5 + 6, 3, 1, "R8");
    do_issue(4, 12, 11, 13, 4, "R4", t6);
    expect_ev(t5 + 7, 1, 4, "R5"); expect_ev(t5 + 13, 2, 4, "R6"); expect_ev(t5 + 14, 3, 4, "R10");
    do_issue(2, 13, 1, 1, 3, "R4", t7);
    expect_ev(t5 + 3, 1, 3, "R5"); expect_ev(t5 + 5, 2, 3, "R6"); expect_ev(t5 + 8, 3, 3, "R7");
    wait_cycle(t5 + 7);
    check(rrs(13) == 4, "R7 write held", rrs(13), 4);
    wait_cycle(t5 + 9);
    check(rrs(13) == 0, "R7 write after read", rrs(13), 0);
    check(rrs(12) == 5, "R10 long op pending", rrs(12), 5);
    wait_idle();

    // Issue in the producer's write cycle; load ignores second source
    do_issue(0, 2, 0, 0, 0, "R4", t8);
    expect_ev(t8 + 1, 1, 0, "R5"); expect_ev(t8 + 2, 2, 0, "R6"); expect_ev(t8 + 3, 3, 0, "R8");
    #16;
    do_issue(2, 4, 2, 3, 3, "R11", t9);
    check(t9 == t8 + 3, "R11 same cycle issue", t9, t8 + 3);
    expect_ev(t8 + 4, 1, 3, "R11"); expect_ev(t8 + 6, 2, 3, "R6"); expect_ev(t8 + 7, 3, 3, "R8");
    do_issue(0, 6, 1, 4, 0, "R9", t10);
    expect_ev(t10 + 1, 1, 0, "R9"); expect_ev(t10 + 2, 2, 0, "R6"); expect_ev(t10 + 3, 3, 0, "R9");
    check(t10 == t8 + 4, "R9 load issue", t10, t8 + 4);
    wait_idle();
    check(rrs_status == '0, "R8 final status", int'(rrs_status != '0), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule